// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the data side of a boundary-scan test path for a row of user I/O pins. It sits between the core logic and the pad buffers. Each pin has a group of three scan cells: one for the value the core drives, one for the core's output enable (active low, so 0 means the pad drives) and one for the value seen at the pad. Every cell has a capture flip-flop, which is part of one serial shift path, and an update flip-flop, which can hold a value for the pad or for the core.

A separate test access port controller supplies a register clock-enable strobe, a shift/capture select and an update strobe. Instruction decode supplies a test-mode select and a global high-impedance control. When test mode is off the pads and the core see each other directly, and the chain can still take snapshots of pin activity. When test mode is on the update flip-flops drive the pads and the core input. Together these give the sample/preload, external test, clamp and high-impedance operations. Power and ground pins have no cells.

Top module: `bscan_chain`

## Requirements
- R1: After reset every capture flip-flop is 0, the data and input update flip-flops are 0 and every output-enable update flip-flop is 1, so that in test mode no pad drives, `pad_out` is 0, `core_in` is 0 and `scan_out` is 0.
- R2: With `test_mode` low and `force_hiz` low, `pad_out` equals `core_out`, `pad_oe_n` equals `core_oe_n` and `core_in` equals `pin_in` in the same cycle, whatever the cells hold.
- R3: A clock edge with `dr_clock` high and `dr_shift` low loads each pin's input cell from `pin_in`, its enable cell from `core_oe_n` and its data cell from `core_out`.
- R4: A clock edge with `dr_clock` and `dr_shift` both high moves every capture bit one position toward `scan_out`, and `scan_in` enters position 0. `scan_out` always shows the capture bit at position 3*PINS-1.
- R5: Chain position 3*g holds pin g's input cell, 3*g+1 holds its enable cell and 3*g+2 holds its data cell. Pin 0 is nearest `scan_in`.
- R6: A clock edge with `dr_update` high copies each capture bit into its update flip-flop. Without that strobe the update flip-flops, and so the pads in test mode, hold still while data is shifted.
- R7: With `test_mode` high, `pad_out[g]` is the data update bit, `pad_oe_n[g]` is the enable update bit (0 drives) and `core_in[g]` is the input update bit.
- R8: With `force_hiz` high every bit of `pad_oe_n` is 1, in either mode and whatever the cells hold.
- R9: When update and shift land on the same edge, the update flip-flops take the chain contents from before that shift.
- R10: An edge with `dr_clock` low leaves every capture bit unchanged, whatever the pins and core do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all cell flip-flops |
| rst | input | 1 | Synchronous reset, active high |
| scan_in | input | 1 | Serial data into chain position 0 |
| scan_out | output | 1 | Serial data from the last chain position |
| dr_clock | input | 1 | Capture flip-flops load on this edge |
| dr_shift | input | 1 | 1 selects shift, 0 selects parallel capture |
| dr_update | input | 1 | Update flip-flops load from capture flip-flops |
| test_mode | input | 1 | 1 lets the update flip-flops drive the pads and core |
| force_hiz | input | 1 | 1 turns every pad output enable off |
| core_out | input | PINS | Data the core wants on each pad |
| core_oe_n | input | PINS | Core output enable per pad, 0 drives |
| pin_in | input | PINS | Value received at each pad |
| pad_out | output | PINS | Data to each pad buffer |
| pad_oe_n | output | PINS | Enable to each pad buffer, 0 drives |
| core_in | output | PINS | Pad value as seen by the core |

## Verification
The update strobe and a shift can fall on the same edge. The risk is that the pads then show data already moved by one position. The bench raises `dr_update`, `dr_clock` and `dr_shift` together after loading a known pattern. It then compares the pads, in test mode, with the pre-shift pattern, and it compares the serial output with the shifted pattern. A second overlap is `force_hiz` against an update that loads drive enables, and the bench checks that the enables stay off in both modes.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Slot of a cell inside one pin group, counted from the scan input side.
  typedef enum logic [1:0] {
    SLOT_IN  = 2'd0,
    SLOT_OE  = 2'd1,
    SLOT_OUT = 2'd2
  } slot_e;

  localparam int unsigned SLOTS_PER_PIN = 3;

  // Absolute chain position of a slot of a given pin.
  function automatic int unsigned chain_pos(input int unsigned pin, input slot_e slot);
    return pin * SLOTS_PER_PIN + int'(slot);
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter bit UPD_RST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic par_in,
  input  logic sdi,
  output logic cap_q,
  output logic upd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
    end else if (cap_en) begin
      cap_q <= shift_sel ? sdi : par_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q <= UPD_RST;
    end else if (upd_en) begin
      upd_q <= cap_q;
    end
  end

  // R3: parallel capture loads the neighbouring core/pin signal
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !shift_sel) |=> (cap_q == $past(par_in)));

  // R4: shift takes the bit of the previous cell
  assert_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (cap_en && shift_sel) |=> (cap_q == $past(sdi)));

  // R10: no register clock, no change
  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(cap_q));

  // R6: update register only moves on the update strobe
  assert_upd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(upd_q));

  // R9: update takes the capture value from before the same edge
  assert_upd_load_R9: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (upd_q == $past(cap_q)));

endmodule

// File: rtl/bscan_pin_group.sv
module bscan_pin_group
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_sel,
  input  logic upd_en,
  input  logic test_mode,
  input  logic force_hiz,
  input  logic sdi,
  input  logic core_out,
  input  logic core_oe_n,
  input  logic pin_in,
  output logic sdo,
  output logic pad_out,
  output logic pad_oe_n,
  output logic core_in
);

  localparam int unsigned S = SLOTS_PER_PIN;

  logic [S:0]   link;
  logic [S-1:0] par;
  logic [S-1:0] upd;

  assign par[SLOT_IN]  = pin_in;
  assign par[SLOT_OE]  = core_oe_n;
  assign par[SLOT_OUT] = core_out;
  assign link[0]       = sdi;

  for (genvar s = 0; s < S; s++) begin : g_slot
    bscan_cell #(
      .UPD_RST(s == int'(SLOT_OE))
    ) i_cell (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .shift_sel(shift_sel),
      .upd_en   (upd_en),
      .par_in   (par[s]),
      .sdi      (link[s]),
      .cap_q    (link[s+1]),
      .upd_q    (upd[s])
    );
  end

  assign sdo = link[S];

  always_comb begin
    if (test_mode) begin
      pad_out  = upd[SLOT_OUT];
      pad_oe_n = upd[SLOT_OE];
      core_in  = upd[SLOT_IN];
    end else begin
      pad_out  = core_out;
      pad_oe_n = core_oe_n;
      core_in  = pin_in;
    end
    if (force_hiz) begin
      pad_oe_n = 1'b1;
    end
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic            dr_clock,
  input  logic            dr_shift,
  input  logic            dr_update,
  input  logic            test_mode,
  input  logic            force_hiz,
  input  logic [PINS-1:0] core_out,
  input  logic [PINS-1:0] core_oe_n,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe_n,
  output logic [PINS-1:0] core_in
);

  localparam int unsigned CHAIN_LEN = PINS * SLOTS_PER_PIN;

  logic [PINS:0] link;

  assign link[0] = scan_in;

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    bscan_pin_group i_group (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (dr_clock),
      .shift_sel(dr_shift),
      .upd_en   (dr_update),
      .test_mode(test_mode),
      .force_hiz(force_hiz),
      .sdi      (link[g]),
      .core_out (core_out[g]),
      .core_oe_n(core_oe_n[g]),
      .pin_in   (pin_in[g]),
      .sdo      (link[g+1]),
      .pad_out  (pad_out[g]),
      .pad_oe_n (pad_oe_n[g]),
      .core_in  (core_in[g])
    );
  end

  assign scan_out = link[PINS];

  // R8: global high-Z wins over every cell
  assert_hiz_R8: assert property (@(posedge clk) disable iff (rst)
    force_hiz |-> (pad_oe_n == {PINS{1'b1}}));

  // R2: transparent path when not in test mode
  assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !force_hiz) |->
      (pad_out == core_out && pad_oe_n == core_oe_n && core_in == pin_in));

  // R4: serial output changes only when the chain is clocked
  assert_sout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !dr_clock |=> $stable(scan_out));

  initial begin
    assert_len_R5: assert (CHAIN_LEN == 3 * PINS);
  end

endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;

  localparam int P = 4;
  localparam int L = 3 * P;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, scan_in, dr_clock, dr_shift, dr_update, test_mode, force_hiz;
  logic [P-1:0] core_out, core_oe_n, pin_in;
  logic         scan_out;
  logic [P-1:0] pad_out, pad_oe_n, core_in;

  bscan_chain #(.PINS(P)) i_bscan_chain (
    .clk(clk), .rst(rst), .scan_in(scan_in), .scan_out(scan_out),
    .dr_clock(dr_clock), .dr_shift(dr_shift), .dr_update(dr_update),
    .test_mode(test_mode), .force_hiz(force_hiz),
    .core_out(core_out), .core_oe_n(core_oe_n), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe_n(pad_oe_n), .core_in(core_in)
  );

  int errors = 0;
  int checks = 0;
  logic [L-1:0] m_cap, m_upd;
  bit done = 0;

  task automatic check(input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [L-1:0] cap_vec();
    logic [L-1:0] v;
    for (int g = 0; g < P; g++) begin
      v[3*g]   = pin_in[g];
      v[3*g+1] = core_oe_n[g];
      v[3*g+2] = core_out[g];
    end
    return v;
  endfunction

  task automatic check_outs(input string req);
    logic [P-1:0] eo, ee, ei;
    for (int g = 0; g < P; g++) begin
      eo[g] = test_mode ? m_upd[3*g+2] : core_out[g];
      ee[g] = force_hiz ? 1'b1 : (test_mode ? m_upd[3*g+1] : core_oe_n[g]);
      ei[g] = test_mode ? m_upd[3*g] : pin_in[g];
    end
    check({req, " pad_out"}, pad_out, eo);
    check({req, " pad_oe_n"}, pad_oe_n, ee);
    check({req, " core_in"}, core_in, ei);
    check({req, " scan_out"}, {{(P-1){1'b0}}, scan_out}, {{(P-1){1'b0}}, m_cap[L-1]});
  endtask

  task automatic step(input string req, input logic c, input logic s, input logic u, input logic sin);
    logic [L-1:0] old;
    dr_clock = c; dr_shift = s; dr_update = u; scan_in = sin;
    @(posedge clk);
    old = m_cap;
    if (u) m_upd = old;
    if (c) m_cap = s ? {old[L-2:0], sin} : cap_vec();
    #1;
    dr_clock = 1'b0; dr_update = 1'b0;
    check_outs(req);
  endtask

  task automatic shift_in(input string req, input logic [L-1:0] v);
    for (int i = L - 1; i >= 0; i--) step(req, 1'b1, 1'b1, 1'b0, v[i]);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] pat;
    rst = 1'b1; scan_in = 0; dr_clock = 0; dr_shift = 0; dr_update = 0;
    test_mode = 1'b1; force_hiz = 1'b0;
    core_out = '0; core_oe_n = '0; pin_in = '0;
    m_cap = '0;
    for (int g = 0; g < P; g++) m_upd[3*g+:3] = 3'b010;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state seen through test mode
    check("R1 pad_oe_n", pad_oe_n, '1);
    check("R1 pad_out", pad_out, '0);
    check("R1 core_in", core_in, '0);
    check_outs("R1");

    // R2: exhaustive transparent sweep
    test_mode = 1'b0;
    for (int v = 0; v < (1 << L); v++) begin
      {core_out, core_oe_n, pin_in} = v[L-1:0];
      #1;
      check_outs("R2");
    end
    @(posedge clk); #1;

    // R3, R5: capture then shift out, several patterns
    for (int k = 0; k < 6; k++) begin
      {core_out, core_oe_n, pin_in} = L'(32'h5A3 * (k + 1) ^ (k << 7));
      step("R3", 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < L; i++) step("R5", 1'b1, 1'b1, 1'b0, i[0]);
    end

    // R6, R7: preload patterns, pads stay still while shifting in test mode
    test_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      pat = L'(32'h9C6 ^ (k * 32'h2B5));
      shift_in("R6", pat);
      step("R7", 1'b0, 1'b0, 1'b1, 1'b0);
      check("R7 pad_out g0", {{(P-1){1'b0}}, pad_out[0]}, {{(P-1){1'b0}}, pat[2]});
    end

    // R8: high-Z in both modes after loading drive enables of 0
    shift_in("R8", '0);
    step("R8", 1'b0, 1'b0, 1'b1, 1'b0);
    force_hiz = 1'b1;
    #1 check("R8 test", pad_oe_n, '1);
    test_mode = 1'b0; core_oe_n = '0;
    #1 check("R8 normal", pad_oe_n, '1);
    force_hiz = 1'b0; test_mode = 1'b1;
    #1 check_outs("R8");

    // R9: update and shift on one edge
    pat = 12'b1010_0110_1100;
    shift_in("R9", pat);
    step("R9", 1'b1, 1'b1, 1'b1, 1'b1);
    check("R9 pad_oe_n", pad_oe_n, {pat[10], pat[7], pat[4], pat[1]});

    // R10: idle edges with moving inputs leave the chain alone
    for (int k = 0; k < 5; k++) begin
      {core_out, core_oe_n, pin_in} = ~L'(k * 32'h111);
      step("R10", 1'b0, 1'b1, 1'b0, ~scan_out);
    end
    for (int i = 0; i < L; i++) step("R10", 1'b1, 1'b1, 1'b0, 1'b0);

    // R4: walking one through the whole chain
    step("R4", 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 1; i < L; i++) step("R4", 1'b1, 1'b1, 1'b0, 1'b0);
    check("R4 last", {{(P-1){1'b0}}, scan_out}, {{(P-1){1'b0}}, 1'b1});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule